// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

A full-duplex serial port that exchanges one character at a time with a peer over four lines: serial clock, master-to-slave data, slave-to-master data and an active-low select. A single shift register carries both directions. The outgoing bit leaves from its top end while the incoming bit enters at its bottom end. After one character, the two ends of the link have therefore swapped their register contents. The most significant bit always travels first.

In master mode the port makes the serial clock from the system clock through a programmable divider. It holds the select line low for the whole character. It uses clock-idle-low timing: data is sampled when the clock rises and changes when the clock falls. In slave mode the external clock, select and incoming data pass through a two-stage synchronizer. Releasing the select line in the middle of a character throws away the partial bit count.

Since there is no holding register, a new transmit character is refused while a character is moving, or while a received character is still unread. A refused write raises a sticky collision flag. The data pins are not tri-stated inside the block. Instead, the block gives an output enable for each driven pin, so that the pad logic floats a line when the port is off or, in slave mode, not selected.

Top module: `spi_port`

## Requirements
- R1: After one complete character (CHAR_W = 8 by default), the master's receive data equals the slave's previously loaded transmit data, and the slave's receive data equals the master's. Bits move most significant first.
- R2: In master mode, busy stays high for exactly (2*CHAR_W+1)*(clk_div+1) system clock cycles after an accepted write. The select output is low throughout that time and high once busy is low.
- R3: The master serial clock is low whenever the port is idle. The master data output changes only when that clock falls and stays stable while it is high.
- R4: While the port is enabled, a transmit write is refused when busy or receive-valid is high. A refused write sets collision and leaves the shift register unchanged. This includes a write in the same cycle as a receive read.
- R5: Collision stays set until a collision-clear pulse, and is low in the cycle after that pulse.
- R6: Receive-valid goes high when a character completes and is low in the cycle after a receive-read pulse.
- R7: In master mode, the serial clock, select and master data output enables are high and the slave data output enable is low. In slave mode, those three enables are low and the slave data output enable equals the inverse of the incoming select.
- R8: With the port disabled, every output enable is low and busy is low. A transmit write is then ignored: it sets no collision and loads nothing.
- R9: In slave mode, releasing select in the middle of a character clears the bit count. Busy goes low, receive-valid is not set, and the next full character is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Port enable |
| master | input | 1 | 1 = master mode, 0 = slave mode |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| tx_data | input | CHAR_W | Character to send |
| tx_write | input | 1 | Load tx_data into the shift register (start in master mode) |
| rx_read | input | 1 | Acknowledge the received character |
| coll_clr | input | 1 | Clear the collision flag |
| rx_data | output | CHAR_W | Shift register contents (received character) |
| busy | output | 1 | Character in progress |
| rx_valid | output | 1 | Unread received character present |
| collision | output | 1 | Sticky flag: a write was refused |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_o | output | 1 | Select output, active low (master) |
| ss_n_oe | output | 1 | Select output enable |
| ss_n_i | input | 1 | Select input, active low (slave) |
| mosi_o | output | 1 | Master-to-slave data output |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| mosi_i | input | 1 | Master-to-slave data input (slave) |
| miso_o | output | 1 | Slave-to-master data output |
| miso_oe | output | 1 | Slave-to-master data output enable |
| miso_i | input | 1 | Slave-to-master data input (master) |

## Verification
A receive read and a transmit write can arrive in the same cycle. The read clears receive-valid, but the write is judged against the valid flag as it stood before that edge, so the write must be refused. The bench provokes this by leaving a finished character unread and then pulsing both inputs together on one edge. It then expects receive-valid low, collision high, busy low and the receive data unchanged. The same refusal logic also meets a write that lands mid-character; random transfers inject such a write and require both the collision flag and an uncorrupted exchange.

// File: rtl/spi_pkg.sv
// Package: shared types of the serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_pkg;
    // Master sequencer states: idle, shifting bits, trailing half period with select held.
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SHIFT = 2'd1,
        M_TAIL  = 2'd2
    } mst_state_e;
endpackage

// File: rtl/spi_sync.sv
// Module: spi_sync
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes: each bit is a level that stays stable for several clocks; the bits
// are not meant to be captured coherently as a group.
module spi_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages so that metastability can settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi_clkgen.sv
// Module: spi_clkgen
// Half-period timer for the master serial clock: tick pulses once every div+1
// cycles while run is high.
// Assumes: div is held constant while run is high; the count restarts when run drops.
module spi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system clocks within a half period; restart on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shifter.sv
// Module: spi_shifter
// Single shift register shared by transmit and receive, plus the one-bit
// sample flop that holds the incoming bit between the sampling and shifting edges.
// Assumes: load, cap and shift are never asserted in the same cycle by the controller.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         cap,
    input  logic         cap_in,
    input  logic         shift,
    output logic [W-1:0] q
);
    logic rx_bit;

    // Hold the bit sampled on the rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n)   rx_bit <= 1'b0;
        else if (cap) rx_bit <= cap_in;
    end

    // Load a new character or move one position towards the top.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], rx_bit};
    end
endmodule

// File: rtl/spi_port.sv
// Module: spi_port (top)
// Full-duplex serial port, master or slave, with one shared shift register.
// Assumes: clock-idle-low timing. In slave mode the external serial clock half
// period is at least four system clocks. In master mode, when paired with a
// synchronizing slave, clk_div is at least 3. Mode and clk_div change only while idle.
module spi_port #(
    parameter int CHAR_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_write,
    input  logic              rx_read,
    input  logic              coll_clr,
    output logic [CHAR_W-1:0] rx_data,
    output logic              busy,
    output logic              rx_valid,
    output logic              collision,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              ss_n_o,
    output logic              ss_n_oe,
    input  logic              ss_n_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i
);
    import spi_pkg::*;

    localparam int                CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(CHAR_W - 1);

    mst_state_e        state;
    logic              m_sck;
    logic              m_tick;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_s, ss_s, mosi_s, sck_prev;
    logic              m_act, s_act, sel;
    logic              s_rise, s_fall;
    logic              accept, refuse, done;
    logic              cap, cap_in, shift;
    logic [CHAR_W-1:0] q;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_n_i, mosi_i}),
        .q     ({sck_s, ss_s, mosi_s})
    );

    assign m_act = enable && master;
    assign s_act = enable && !master;
    assign sel   = !ss_s;

    spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_act && (state != M_IDLE)),
        .div   (clk_div),
        .tick  (m_tick)
    );

    // Edges of the synchronized external serial clock, only while selected.
    assign s_rise = s_act && sel &&  sck_s && !sck_prev;
    assign s_fall = s_act && sel && !sck_s &&  sck_prev;

    // Control decisions shared by both modes.
    assign busy   = master ? (state != M_IDLE) : (bit_cnt != '0);
    assign accept = tx_write && enable && !busy && !rx_valid;
    assign refuse = tx_write && enable && (busy || rx_valid);
    assign cap    = (m_tick && (state == M_SHIFT) && !m_sck) || s_rise;
    assign cap_in = master ? miso_i : mosi_s;
    assign shift  = (m_tick && (state == M_SHIFT) && m_sck) || s_fall;
    assign done   = (m_tick && (state == M_TAIL)) || (s_fall && (bit_cnt == LAST));

    spi_shifter #(.W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (tx_data),
        .cap      (cap),
        .cap_in   (cap_in),
        .shift    (shift),
        .q        (q)
    );

    // Remember the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Master sequencer: toggle the serial clock each half period, then hold select one extra half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !m_act) begin
            state <= M_IDLE;
            m_sck <= 1'b0;
        end else begin
            unique case (state)
                M_IDLE: if (accept) begin
                    state <= M_SHIFT;
                    m_sck <= 1'b0;
                end
                M_SHIFT: if (m_tick) begin
                    m_sck <= !m_sck;
                    if (m_sck && (bit_cnt == LAST)) state <= M_TAIL;
                end
                M_TAIL: if (m_tick) state <= M_IDLE;
                default: state <= M_IDLE;
            endcase
        end
    end

    // Bit counter: counts falling edges; a slave counter resets when select is released.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_cnt <= '0;
        end else if (master) begin
            if (accept)
                bit_cnt <= '0;
            else if (m_tick && (state == M_SHIFT) && m_sck)
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end else begin
            if (!sel)
                bit_cnt <= '0;
            else if (s_fall)
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Receive-valid flag: completion sets it, a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_valid <= 1'b0;
        else if (done)    rx_valid <= 1'b1;
        else if (rx_read) rx_valid <= 1'b0;
    end

    // Sticky collision flag: a refused write sets it, a clear pulse resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        collision <= 1'b0;
        else if (refuse)   collision <= 1'b1;
        else if (coll_clr) collision <= 1'b0;
    end

    assign rx_data = q;
    assign sck_o   = m_sck;
    assign ss_n_o  = (state == M_IDLE);
    assign mosi_o  = q[CHAR_W-1];
    assign miso_o  = q[CHAR_W-1];
    assign sck_oe  = m_act;
    assign ss_n_oe = m_act;
    assign mosi_oe = m_act;
    assign miso_oe = s_act && !ss_n_i;
endmodule

// File: rtl/spi_port_chk.sv
// Module: spi_port_chk
// Property checker for spi_port, attached by bind.
// Assumes: it observes the top's ports and a few internal nets only; it drives nothing.
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic master,
    input logic tx_write,
    input logic rx_read,
    input logic busy,
    input logic rx_valid,
    input logic collision,
    input logic sck_o,
    input logic ss_n_o,
    input logic mosi_o,
    input logic mosi_oe,
    input logic miso_oe,
    input logic ss_sync,
    input logic done
);
    a_r4_refused_write_collides: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tx_write && (busy || rx_valid)) |=> collision);

    a_r6_read_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !done) |=> !rx_valid);

    a_r3_data_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master && busy && sck_o && $past(sck_o)) |-> $stable(mosi_o));

    a_r3_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master && !busy) |-> !sck_o);

    a_r2_select_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master && busy) |-> !ss_n_o);

    a_r9_release_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !master && ss_sync) |=> !busy);

    a_r8_disabled_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!mosi_oe && !miso_oe));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .master    (master),
    .tx_write  (tx_write),
    .rx_read   (rx_read),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .collision (collision),
    .sck_o     (sck_o),
    .ss_n_o    (ss_n_o),
    .mosi_o    (mosi_o),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .ss_sync   (ss_s),
    .done      (done)
);

// File: tb/tb_spi_port.sv
// Bench: two ports (dut and peer) wired back to back through a resolved bus.
// Each transfer picks one port as master at random; a few directed cases cover
// collisions, the read/write coincidence, disabling and the slave abort.
module tb_spi_port;
    localparam int W  = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [1:0]    en, mst, wr, rd, clr;
    logic [DW-1:0] div;
    logic [W-1:0]  txd [2];
    logic [W-1:0]  rxd [2];
    logic [1:0]    busy, rxv, coll;
    logic [1:0]    sck_o, sck_oe, ss_o, ss_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic          sck_bus, ss_bus, mosi_bus, miso_bus;

    assign sck_bus  = sck_oe[0]  ? sck_o[0]  : (sck_oe[1]  ? sck_o[1]  : 1'b0);
    assign ss_bus   = ss_oe[0]   ? ss_o[0]   : (ss_oe[1]   ? ss_o[1]   : 1'b1);
    assign mosi_bus = mosi_oe[0] ? mosi_o[0] : (mosi_oe[1] ? mosi_o[1] : 1'b0);
    assign miso_bus = miso_oe[0] ? miso_o[0] : (miso_oe[1] ? miso_o[1] : 1'b0);

    spi_port #(.CHAR_W(W), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(en[0]), .master(mst[0]), .clk_div(div),
        .tx_data(txd[0]), .tx_write(wr[0]), .rx_read(rd[0]), .coll_clr(clr[0]),
        .rx_data(rxd[0]), .busy(busy[0]), .rx_valid(rxv[0]), .collision(coll[0]),
        .sck_o(sck_o[0]), .sck_oe(sck_oe[0]), .sck_i(sck_bus),
        .ss_n_o(ss_o[0]), .ss_n_oe(ss_oe[0]), .ss_n_i(ss_bus),
        .mosi_o(mosi_o[0]), .mosi_oe(mosi_oe[0]), .mosi_i(mosi_bus),
        .miso_o(miso_o[0]), .miso_oe(miso_oe[0]), .miso_i(miso_bus));

    spi_port #(.CHAR_W(W), .DIV_W(DW)) peer (
        .clk(clk), .rst_n(rst_n), .enable(en[1]), .master(mst[1]), .clk_div(div),
        .tx_data(txd[1]), .tx_write(wr[1]), .rx_read(rd[1]), .coll_clr(clr[1]),
        .rx_data(rxd[1]), .busy(busy[1]), .rx_valid(rxv[1]), .collision(coll[1]),
        .sck_o(sck_o[1]), .sck_oe(sck_oe[1]), .sck_i(sck_bus),
        .ss_n_o(ss_o[1]), .ss_n_oe(ss_oe[1]), .ss_n_i(ss_bus),
        .mosi_o(mosi_o[1]), .mosi_oe(mosi_oe[1]), .mosi_i(mosi_bus),
        .miso_o(miso_o[1]), .miso_oe(miso_oe[1]), .miso_i(miso_bus));

    int n_chk = 0;
    int n_fail = 0;

    // Record one check; print a failure line with actual and expected values.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected master character length in system clocks.
    function automatic int exp_cycles(input int d);
        return (2 * W + 1) * (d + 1);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // One character: m is the master index. Optional mid-transfer write probe and final read.
    task automatic xfer(input int m, input logic [W-1:0] a, input logic [W-1:0] b,
                        input int d, input bit probe, input bit do_read);
        int s = 1 - m;
        int n = 0;
        int bad = 0;
        logic p_sck, p_mosi;
        @(negedge clk);
        mst[m] = 1'b1; mst[s] = 1'b0; div = DW'(d);
        @(negedge clk);
        txd[s] = b; wr[s] = 1'b1;
        @(negedge clk);
        wr[s] = 1'b0;
        chk(coll[s] == 1'b0, "R4 slave load accepted", coll[s], 0);
        txd[m] = a; wr[m] = 1'b1;
        @(negedge clk);
        wr[m] = 1'b0;
        p_sck = sck_o[m]; p_mosi = mosi_o[m];
        while (busy[m]) begin
            n++;
            if (p_sck && sck_o[m] && (mosi_o[m] != p_mosi)) bad++;
            if (ss_bus != 1'b0) bad++;
            if (n == 3) chk(miso_oe[s] == 1'b1, "R7 selected slave drives", miso_oe[s], 1);
            if (probe && n == 6) begin txd[m] = ~a; wr[m] = 1'b1; end
            if (n == 7) wr[m] = 1'b0;
            p_sck = sck_o[m]; p_mosi = mosi_o[m];
            @(negedge clk);
        end
        wr[m] = 1'b0;
        chk(n == exp_cycles(d), "R2 master busy length", n, exp_cycles(d));
        chk(bad == 0, "R3/R2 data stable high, select low", bad, 0);
        chk(ss_bus == 1'b1 && sck_o[m] == 1'b0, "R2/R3 idle select high clock low",
            {ss_bus, sck_o[m]}, 2);
        repeat (3) @(negedge clk);
        chk(rxv == 2'b11, "R6 both valid after character", rxv, 3);
        chk(rxd[m] == b, "R1 master received slave data", rxd[m], b);
        chk(rxd[s] == a, "R1 slave received master data", rxd[s], a);
        if (probe) begin
            repeat (4) @(negedge clk);
            chk(coll[m] == 1'b1, "R4/R5 mid-transfer write collided, sticky", coll[m], 1);
            clr[m] = 1'b1;
            @(negedge clk);
            clr[m] = 1'b0;
            chk(coll[m] == 1'b0, "R5 collision cleared", coll[m], 0);
        end
        if (do_read) begin
            rd = 2'b11;
            @(negedge clk);
            rd = 2'b00;
            chk(rxv == 2'b00, "R6 read clears valid", rxv, 0);
        end
    endtask

    initial begin
        logic [W-1:0] keep;
        void'($urandom(32'h1234_5EED));
        en = '0; mst = '0; wr = '0; rd = '0; clr = '0; div = DW'(3);
        txd[0] = '0; txd[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state and disabled port.
        chk(busy == 2'b00 && rxv == 2'b00 && coll == 2'b00, "R6/R8 reset flags low",
            {busy, rxv, coll}, 0);
        chk({sck_oe, ss_oe, mosi_oe, miso_oe} == '0, "R8 no enables when disabled",
            {sck_oe, ss_oe, mosi_oe, miso_oe}, 0);
        txd[0] = 8'hA5; wr[0] = 1'b1;
        @(negedge clk);
        wr[0] = 1'b0;
        @(negedge clk);
        chk(busy[0] == 1'b0 && coll[0] == 1'b0 && rxd[0] == 8'h00,
            "R8 disabled write ignored", {busy[0], coll[0], rxd[0]}, 0);

        // Output enables per mode.
        en = 2'b11; mst = 2'b01;
        @(negedge clk);
        chk({sck_oe[0], ss_oe[0], mosi_oe[0], miso_oe[0]} == 4'b1110, "R7 master enables",
            {sck_oe[0], ss_oe[0], mosi_oe[0], miso_oe[0]}, 4'b1110);
        chk({sck_oe[1], ss_oe[1], mosi_oe[1], miso_oe[1]} == 4'b0000,
            "R7 unselected slave floats", {sck_oe[1], ss_oe[1], mosi_oe[1], miso_oe[1]}, 0);
        chk(sck_o[0] == 1'b0, "R3 idle clock low", sck_o[0], 0);

        // Directed transfers, both directions and extreme patterns.
        xfer(0, 8'hA5, 8'h3C, 3, 1'b0, 1'b1);
        xfer(1, 8'h00, 8'hFF, 4, 1'b0, 1'b1);
        xfer(0, 8'h80, 8'h01, 7, 1'b1, 1'b1);

        // Unread character: writes refused, register unchanged.
        xfer(0, 8'h96, 8'h69, 3, 1'b0, 1'b0);
        txd[0] = 8'h11; txd[1] = 8'h22; wr = 2'b11;
        @(negedge clk);
        wr = 2'b00;
        chk(coll == 2'b11, "R4 write refused while valid", coll, 3);
        chk(rxd[0] == 8'h69 && rxd[1] == 8'h96, "R4 register unchanged after refusal",
            {rxd[0], rxd[1]}, 16'h6996);
        clr = 2'b11;
        @(negedge clk);
        clr = 2'b00;
        chk(coll == 2'b00, "R5 clear both", coll, 0);

        // Same-cycle read and write on dut.
        txd[0] = 8'h5F; wr[0] = 1'b1; rd[0] = 1'b1;
        @(negedge clk);
        wr[0] = 1'b0; rd[0] = 1'b0;
        chk(rxv[0] == 1'b0 && coll[0] == 1'b1 && busy[0] == 1'b0 && rxd[0] == 8'h69,
            "R4/R6 read with write: write refused", {rxv[0], coll[0], busy[0], rxd[0]},
            {1'b0, 1'b1, 1'b0, 8'h69});
        rd[1] = 1'b1; clr[0] = 1'b1;
        @(negedge clk);
        rd[1] = 1'b0; clr[0] = 1'b0;

        // Slave abort: master disabled mid-character releases select.
        mst = 2'b01; div = DW'(5);
        @(negedge clk);
        txd[1] = 8'h81; wr[1] = 1'b1;
        @(negedge clk);
        wr[1] = 1'b0; txd[0] = 8'h5A; wr[0] = 1'b1;
        @(negedge clk);
        wr[0] = 1'b0;
        repeat (30) @(negedge clk);
        keep = rxd[0];
        en[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy[1] == 1'b0 && rxv[1] == 1'b0, "R9 released slave idle, no valid",
            {busy[1], rxv[1]}, 0);
        chk(miso_oe[1] == 1'b0, "R7 released slave floats", miso_oe[1], 0);
        chk({sck_oe[0], ss_oe[0], mosi_oe[0], busy[0]} == '0, "R8 disabled master quiet",
            {sck_oe[0], ss_oe[0], mosi_oe[0], busy[0]}, 0);
        chk(rxd[0] == keep, "R8 disabled shift register holds", rxd[0], keep);
        en[0] = 1'b1;
        xfer(0, 8'hC3, 8'h7E, 5, 1'b0, 1'b1);   // R9 recovery

        // Constrained random transfers.
        for (int i = 0; i < 40; i++) begin
            int m = int'($urandom % 2);
            int d = 3 + int'($urandom % 5);
            logic [W-1:0] a = W'($urandom);
            logic [W-1:0] b = W'($urandom);
            xfer(m, a, b, d, ($urandom % 3) == 0, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule